// File: doc/BRIEF.md
# Priority Interrupt Controller

This block gathers interrupt requests from a set of external request lines (eight by default) and one non-maskable line. It decides which of them to present to a processor on a single `irq` output. Each maskable line can capture either a held level or a single transition, with a per-line polarity. The processor answers with a one-cycle acknowledge pulse. The controller then returns the vector number of the granted source and marks that source as in service. An end-of-service pulse closes the highest open service level again.

Three arbitration models can be selected at run time:
- **Latest-request-wins:** every line has equal rank.
- **Fixed:** the lowest line number wins.
- **Rotating:** the line just served drops to the bottom of the order.

An in-service register tracks nested servicing, so requests that may not interrupt the current handler are held off. Several devices may share one line through a wired OR. The raw per-line request status can be read back, so software can poll to find which device is asking.

A small register port sets the enables, the trigger mode, the polarity, the arbitration model and the vector base. The same port reads back the status and service state.

Top module: `prio_intc`

## Requirements
- R1: After reset `irq` and `vector` are 0, the enable, trigger-mode, polarity, base, status and service registers read 0, and the model register (address 3) reads 1 (fixed).
- R2: A line in level mode (trigger-mode bit 0) requests only while its synchronized input is active (high when its polarity bit is 0, low when 1). If the input returns inactive before acknowledge, no request and no status bit remain.
- R3: A line in edge mode (trigger-mode bit 1) latches a pending bit on a rising input (polarity 0) or a falling input (polarity 1). The bit is held after the input returns, shows in status (address 5), and is cleared by the acknowledge that grants that line.
- R4: A line whose enable bit (address 0) is 0 never raises `irq`, yet its request still shows in the status register.
- R5: In fixed model (address 3 value 1) the lowest-numbered eligible line is granted. Acknowledge loads `vector` with base (address 4) plus the line index, and `vector` changes on no other cycle than one following an acknowledge.
- R6: In fixed model, while line k is in service, requests from lines k and above are held off. A request from a line below k raises `irq` and can be acknowledged, which nests service.
- R7: An end-of-service pulse clears the non-maskable in-service bit if set; otherwise it clears the lowest-numbered set in-service bit (address 6), reopening the levels it held off.
- R8: In latest model (address 3 value 0) the line whose enabled request became active most recently is granted. If that line no longer requests, the lowest-numbered eligible line is granted. While any maskable line is in service, all maskable requests are held off.
- R9: In rotating model (address 3 value 2), after line g is acknowledged, line g+1 (modulo the line count) becomes the highest priority and g the lowest. Any maskable line in service holds off all maskable requests.
- R10: The non-maskable line latches on a rising edge and ignores the enables. It outranks and preempts every maskable line and returns vector base+8 (base plus line count). Only its own service state holds it off. Address 7 reads {pending, in-service} in bits 1 and 0.
- R11: An acknowledge with no eligible request returns base+9 (base plus line count plus one) and changes no pending or service state.
- R12: `irq` is registered. After a level input becomes active, `irq` stays low over the first two rising clock edges and is high after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | N | Maskable request lines, asynchronous |
| nmi_line | input | 1 | Non-maskable request line, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational from address) |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| end_svc | input | 1 | One-cycle end-of-service pulse |
| irq | output | 1 | Interrupt request to the processor |
| vector | output | DW | Vector of the last acknowledge |

## Verification
A corrupted in-service bit shows at the ports within one acknowledge. Either a request that should preempt leaves `irq` low, or a held-off line wins and returns the wrong vector, and address 6 disagrees after the next end-of-service. A stuck pending bit keeps `irq` high three edges after the input has gone idle. A wrong rotation pointer or latest-line register shows on the second acknowledge of a sequence, where the granted vector differs from the fixed-order answer. The non-maskable path is checked for preemption and for self-blocking across two back-to-back edges.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_lines,
  input  logic          nmi_line,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          int_ack,
  input  logic          end_svc,
  output logic          irq,
  output logic [DW-1:0] vector
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [1:0] M_LATEST = 2'd0;
  localparam logic [1:0] M_FIXED  = 2'd1;
  localparam logic [1:0] M_ROT    = 2'd2;

  logic [N-1:0] s1, s2, s3;
  logic         n1, n2, n3;
  logic [N-1:0] en, edge_m, pol, pend_e, isr, eff_q;
  logic [1:0]   model;
  logic [DW-1:0] vbase;
  logic         nmi_pend, nmi_isr;
  logic [IW-1:0] rot, last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      n1 <= 1'b0; n2 <= 1'b0; n3 <= 1'b0;
    end else begin
      s1 <= irq_lines; s2 <= s1; s3 <= s2;
      n1 <= nmi_line;  n2 <= n1; n3 <= n2;
    end
  end

  logic [N-1:0] act, act_q, rise, req, eff, ok, elig, newr;
  logic         nmi_rise, nmi_go, grant_any;
  logic         rot_mode, latest_mode;

  assign act       = s2 ^ pol;
  assign act_q     = s3 ^ pol;
  assign rise      = act & ~act_q;
  assign req       = (edge_m & pend_e) | (~edge_m & act);
  assign eff       = req & en;
  assign newr      = eff & ~eff_q;
  assign nmi_rise  = n2 & ~n3;
  assign nmi_go    = nmi_pend & ~nmi_isr;
  assign rot_mode    = (model == M_ROT);
  assign latest_mode = (model == M_LATEST);

  always_comb begin
    logic blk;
    blk = 1'b0;
    ok  = '0;
    if (!nmi_isr) begin
      if (rot_mode || latest_mode) begin
        ok = {N{~|isr}};
      end else begin
        for (int i = 0; i < N; i++) begin
          blk   = blk | isr[i];
          ok[i] = ~blk;
        end
      end
    end
  end

  assign elig      = eff & ok;
  assign grant_any = nmi_go | (|elig);

  logic [IW-1:0] win;
  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      idx = ((rot_mode ? int'(rot) : 0) + k) % N;
      if (!found && elig[idx]) begin
        win   = IW'(idx);
        found = 1'b1;
      end
    end
    if (latest_mode && elig[last]) win = last;
  end

  logic [IW-1:0] newest;
  always_comb begin
    newest = last;
    for (int i = N - 1; i >= 0; i--)
      if (newr[i]) newest = IW'(i);
  end

  logic [N-1:0] isr_set, isr_clr, pend_clr, eoi_low;
  logic         nmi_set, nmi_clr;

  always_comb begin
    logic seen;
    seen    = 1'b0;
    eoi_low = '0;
    for (int i = 0; i < N; i++) begin
      if (isr[i] && !seen) begin
        eoi_low[i] = 1'b1;
        seen       = 1'b1;
      end
    end
  end

  always_comb begin
    isr_set  = '0;
    pend_clr = '0;
    nmi_set  = 1'b0;
    if (int_ack && nmi_go) begin
      nmi_set = 1'b1;
    end else if (int_ack && (|elig)) begin
      isr_set[win]  = 1'b1;
      pend_clr[win] = 1'b1;
    end
    nmi_clr = end_svc && nmi_isr;
    isr_clr = (end_svc && !nmi_isr) ? eoi_low : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= '0; edge_m <= '0; pol <= '0;
      model <= M_FIXED; vbase <= '0;
      pend_e <= '0; isr <= '0; eff_q <= '0;
      nmi_pend <= 1'b0; nmi_isr <= 1'b0;
      rot <= '0; last <= '0;
      irq <= 1'b0; vector <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: en     <= cfg_wdata[N-1:0];
          3'd1: edge_m <= cfg_wdata[N-1:0];
          3'd2: pol    <= cfg_wdata[N-1:0];
          3'd3: model  <= cfg_wdata[1:0];
          3'd4: vbase  <= cfg_wdata;
          default: ;
        endcase
      end
      pend_e   <= ((pend_e & ~pend_clr) | rise) & edge_m;
      nmi_pend <= (nmi_pend & ~nmi_set) | nmi_rise;
      nmi_isr  <= (nmi_isr & ~nmi_clr) | nmi_set;
      isr      <= (isr & ~isr_clr) | isr_set;
      eff_q    <= eff;
      last     <= newest;
      irq      <= grant_any;
      if (int_ack) begin
        if (nmi_go)
          vector <= vbase + DW'(N);
        else if (|elig) begin
          vector <= vbase + DW'(win);
          if (rot_mode) rot <= (int'(win) == N - 1) ? '0 : win + IW'(1);
        end else
          vector <= vbase + DW'(N + 1);
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = DW'(en);
      3'd1:    cfg_rdata = DW'(edge_m);
      3'd2:    cfg_rdata = DW'(pol);
      3'd3:    cfg_rdata = DW'(model);
      3'd4:    cfg_rdata = vbase;
      3'd5:    cfg_rdata = DW'(req);
      3'd6:    cfg_rdata = DW'(isr);
      default: cfg_rdata = DW'({nmi_pend, nmi_isr});
    endcase
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          int_ack,
  input logic          end_svc,
  input logic          grant_any,
  input logic          nmi_isr,
  input logic [N-1:0]  isr,
  input logic [DW-1:0] vector,
  input logic [DW-1:0] vbase
);
  // R10
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_isr && int_ack && !end_svc) |=> (isr == $past(isr)));

  // R7
  eoi_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (end_svc && nmi_isr) |=> !nmi_isr);

  // R11
  spur_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !grant_any) |=> (vector == $past(vbase) + DW'(N + 1)));

  // R5
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_ack |=> $stable(vector));

  // R6
  ack_isr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && grant_any) |=> ((|isr) || nmi_isr));
endmodule

bind prio_intc prio_intc_chk #(.N(N), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_ack(int_ack), .end_svc(end_svc),
  .grant_any(grant_any), .nmi_isr(nmi_isr), .isr(isr),
  .vector(vector), .vbase(vbase)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
  localparam int CLK_NS = 10;
  localparam int N = 8;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic nmi_line = 1'b0, cfg_we = 1'b0, int_ack = 1'b0, end_svc = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata, vector;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  prio_intc #(.N(N), .DW(DW)) i_prio_intc (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_line(nmi_line),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .int_ack(int_ack), .end_svc(end_svc),
    .irq(irq), .vector(vector));

  // lines, expected irq, expected vector (fixed model, base 8'h20) - R5
  localparam logic [16:0] TBL [5] = '{
    {8'h01, 1'b1, 8'h20},
    {8'h80, 1'b1, 8'h27},
    {8'h90, 1'b1, 8'h24},
    {8'h06, 1'b1, 8'h21},
    {8'h00, 1'b0, 8'h00}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic ack();
    int_ack = 1'b1; tick(1); int_ack = 1'b0;
  endtask

  task automatic eoi();
    end_svc = 1'b1; tick(1); end_svc = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] d;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 vector", vector, 0);
    rd(3'd3, d); chk("R1 model", d, 1);
    rd(3'd0, d); chk("R1 enable", d, 0);
    rd(3'd5, d); chk("R1 status", d, 0);
    rd(3'd6, d); chk("R1 service", d, 0);

    wr(3'd4, 8'h20);
    wr(3'd0, 8'hFF);

    // table walk: R5 fixed priority, R2 level requests
    for (int k = 0; k < 5; k++) begin
      irq_lines = TBL[k][16:9];
      tick(4);
      chk("R5 table irq", irq, TBL[k][8]);
      if (TBL[k][8]) begin
        ack();
        chk("R5 table vector", vector, TBL[k][7:0]);
      end
      irq_lines = '0;
      tick(4);
      eoi();
      tick(2);
    end

    // R12 irq latency
    irq_lines = 8'h80;
    tick(2); chk("R12 irq before third edge", irq, 0);
    tick(1); chk("R12 irq after third edge", irq, 1);
    irq_lines = '0; tick(4);
    chk("R12 irq drops", irq, 0);

    // R2 level request lost when dropped
    irq_lines = 8'h08; tick(1); irq_lines = '0;
    tick(6);
    chk("R2 lost irq", irq, 0);
    rd(3'd5, d); chk("R2 lost status", d, 0);

    // R3 rising edge latch
    wr(3'd1, 8'h24);
    irq_lines = 8'h04; tick(3); irq_lines = '0; tick(4);
    chk("R3 rise irq", irq, 1);
    rd(3'd5, d); chk("R3 pending status", d, 8'h04);
    ack(); chk("R3 rise vector", vector, 8'h22);
    rd(3'd5, d); chk("R3 cleared by ack", d, 0);
    eoi(); tick(3);
    chk("R3 irq after service", irq, 0);

    // R3 falling edge latch
    wr(3'd2, 8'h20);
    irq_lines = 8'h20; tick(6);
    chk("R3 no edge on rise with falling polarity", irq, 0);
    irq_lines = '0; tick(5);
    chk("R3 fall irq", irq, 1);
    ack(); chk("R3 fall vector", vector, 8'h25);
    eoi(); tick(3);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); tick(3);

    // R4 enable mask
    wr(3'd0, 8'hFD);
    irq_lines = 8'h02; tick(5);
    chk("R4 masked irq", irq, 0);
    rd(3'd5, d); chk("R4 masked status visible", d, 8'h02);
    irq_lines = '0; wr(3'd0, 8'hFF); tick(4);

    // R6 / R7 nesting in fixed model
    irq_lines = 8'h10; tick(4);
    ack(); chk("R6 first vector", vector, 8'h24);
    irq_lines = 8'h50; tick(5);
    chk("R6 lower held off", irq, 0);
    irq_lines = 8'h54; tick(4);
    chk("R6 higher preempts", irq, 1);
    ack(); chk("R6 nested vector", vector, 8'h22);
    rd(3'd6, d); chk("R6 nested service", d, 8'h14);
    eoi();
    rd(3'd6, d); chk("R7 eoi clears highest", d, 8'h10);
    irq_lines = 8'h40; tick(4);
    chk("R7 line4 still holds line6", irq, 0);
    eoi(); tick(2);
    chk("R7 reopened", irq, 1);
    ack(); chk("R7 reopened vector", vector, 8'h26);
    irq_lines = '0; tick(3); eoi(); tick(3);

    // R10 non-maskable
    irq_lines = 8'h08; tick(4);
    ack(); chk("R10 setup vector", vector, 8'h23);
    wr(3'd0, 8'h00);
    nmi_line = 1'b1; tick(2); nmi_line = 1'b0; tick(4);
    chk("R10 preempt irq", irq, 1);
    ack(); chk("R10 vector", vector, 8'h28);
    rd(3'd7, d); chk("R10 status after ack", d, 8'h01);
    nmi_line = 1'b1; tick(2); nmi_line = 1'b0; tick(4);
    chk("R10 held by own service", irq, 0);
    rd(3'd7, d); chk("R10 second pending", d, 8'h03);
    eoi(); tick(2);
    rd(3'd6, d); chk("R7 nmi cleared first", d, 8'h08);
    chk("R10 second nmi raised", irq, 1);
    ack(); chk("R10 second vector", vector, 8'h28);
    eoi(); eoi(); irq_lines = '0; tick(4);
    rd(3'd6, d); chk("R7 all service closed", d, 0);
    wr(3'd0, 8'hFF);

    // R11 spurious acknowledge
    ack(); chk("R11 spurious vector", vector, 8'h29);
    rd(3'd6, d); chk("R11 no service change", d, 0);
    rd(3'd7, d); chk("R11 no nmi change", d, 0);

    // R8 latest model
    wr(3'd3, 8'h00);
    irq_lines = 8'h02; tick(4);
    irq_lines = 8'h42; tick(4);
    ack(); chk("R8 latest vector", vector, 8'h26);
    irq_lines = 8'h43; tick(4);
    chk("R8 all held while serviced", irq, 0);
    irq_lines = 8'h03; tick(3); eoi(); tick(3);
    ack(); chk("R8 latest after service", vector, 8'h20);
    irq_lines = '0; tick(3); eoi(); tick(3);

    // R9 rotating model
    wr(3'd3, 8'h02);
    irq_lines = 8'h24; tick(4);
    ack(); chk("R9 first", vector, 8'h22); eoi(); tick(2);
    ack(); chk("R9 rotated", vector, 8'h25); eoi(); tick(2);
    ack(); chk("R9 wrapped", vector, 8'h22); eoi();
    irq_lines = '0; tick(4);
    chk("R9 idle", irq, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule